// File: doc/BRIEF.md
# Dual Cascadable Programmable Timer

This block holds two 8-bit down-counters, timer 0 and timer 1. Each one steps at the rate of its own prescaler, and each prescaler is fed by one of two oscillator strobes, a slow one and a fast one. Each timer has reload data and compare data. Each drives one output pin, which either toggles on every underflow or carries a PWM waveform set by the compare value. Each timer raises an underflow event and a compare-match event. These latch into flags that software clears by writing a one. A mask gates each flag onto a single interrupt request line.

Two modes change where a timer's steps come from. In event mode, timer 0 steps on each rising edge of an external event input, and its source-select bit has no effect. In cascade mode, timer 1 steps only when timer 0 underflows, so the pair forms one 16-bit timer. In that mode timer 1's source select and run bit have no effect, and timer 1's compare match and PWM output use the 16-bit values. All controls sit behind a 4-bit-wide synchronous register bus with a 5-bit address. Reads are combinational.

Top module: `ptmr_dual`

## Requirements
- R1: All registers reset to 0. The control registers hold only bits [1:0] and read their other bits as 0:
  - source select at address 0 (bit i is timer i);
  - mode at address 1 (bit 0 is event mode, bit 1 is cascade);
  - run at address 2;
  - PWM select at address 3.
  Compare data sits at addresses 4 to 7 (timer 0 low and high nibble, then timer 1 low and high nibble). Reload data sits at addresses 8 to 11 in the same order. Unmapped addresses read 0.
- R2: A source-select bit of 0 feeds that timer's prescaler from `slow_tick`, and 1 feeds it from `fast_tick`. A running prescaler gives one step for every PRE_DIV source strobes.
- R3: In event mode, timer 0 steps once on each rising edge of `evt_in`. Its source-select bit and prescaler have no effect.
- R4: A timer whose run bit is 0 holds its reload value as its count.
- R5: Counts read at addresses 16 to 19 (timer 0 low, timer 0 high, timer 1 low, timer 1 high). On each step of a running timer, a count above 0 decrements. A count of 0 reloads and sets that timer's underflow flag.
- R6: With PWM select at 0, a timer's output starts low after reset and toggles on each of that timer's underflows.
- R7: With PWM select at 1, a timer's output is high while its count is greater than its compare data and low otherwise.
- R8: The flags sit at address 12: bit 0 is underflow of timer 0, bit 1 is underflow of timer 1, bit 2 is compare match of timer 0, and bit 3 is compare match of timer 1. Writing 1 to a bit clears it and writing 0 has no effect. A new event in the same cycle as the clear wins.
- R9: `irq` is the OR of each flag ANDed with its mask bit. The mask sits at address 13 with the same bit order, and 1 enables. Flags still set while their mask bit is 0.
- R10: In cascade mode, timer 1 uses timer 0's run bit and steps only on timer 0's underflow. Timer 1 underflows when timer 0 underflows while timer 1's count is 0.
- R11: In cascade mode, timer 1's PWM output compares the 16-bit count {timer 1, timer 0} with the 16-bit compare data {timer 1, timer 0}.
- R12: A compare-match flag sets on a step whose resulting count equals the compare data. In cascade mode, timer 1's match uses the 16-bit count and compare data on timer 0's steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe from the slow oscillator |
| fast_tick | input | 1 | One-cycle strobe from the fast oscillator |
| evt_in | input | 1 | External event level; rising edges count in event mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr` |
| tmr_out | output | 2 | Timer outputs, bit i for timer i |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several properties on every cycle:
- a stopped timer holds its reload value, and a timer reloads after underflow;
- a flag stays set until it is written with 1, and clears when written;
- timer 0's count stays still in event mode between edges, whatever its source select says;
- timer 1's count in cascade mode changes only on timer 0's underflow.

Only the bench's scenarios can show the rest, because these depend on long runs of history: prescaler rates from each source, PWM duty against compare data, 16-bit compare matches, toggle sequences, and flags setting while masked. The bench runs its behavioural model beside the block through slow, fast, event and cascade runs.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
   localparam int unsigned PT_ADDR_W = 5;
   localparam int unsigned PT_NEVT   = 4;

   localparam logic [PT_ADDR_W-1:0] A_SRC   = 5'd0;
   localparam logic [PT_ADDR_W-1:0] A_MODE  = 5'd1;
   localparam logic [PT_ADDR_W-1:0] A_RUN   = 5'd2;
   localparam logic [PT_ADDR_W-1:0] A_PWM   = 5'd3;
   localparam logic [PT_ADDR_W-1:0] A_CMP0L = 5'd4;
   localparam logic [PT_ADDR_W-1:0] A_CMP0H = 5'd5;
   localparam logic [PT_ADDR_W-1:0] A_CMP1L = 5'd6;
   localparam logic [PT_ADDR_W-1:0] A_CMP1H = 5'd7;
   localparam logic [PT_ADDR_W-1:0] A_RLD0L = 5'd8;
   localparam logic [PT_ADDR_W-1:0] A_RLD0H = 5'd9;
   localparam logic [PT_ADDR_W-1:0] A_RLD1L = 5'd10;
   localparam logic [PT_ADDR_W-1:0] A_RLD1H = 5'd11;
   localparam logic [PT_ADDR_W-1:0] A_FLAG  = 5'd12;
   localparam logic [PT_ADDR_W-1:0] A_MASK  = 5'd13;
   localparam logic [PT_ADDR_W-1:0] A_CNT0L = 5'd16;
   localparam logic [PT_ADDR_W-1:0] A_CNT0H = 5'd17;
   localparam logic [PT_ADDR_W-1:0] A_CNT1L = 5'd18;
   localparam logic [PT_ADDR_W-1:0] A_CNT1H = 5'd19;

   // event bit positions inside the flag and mask registers
   localparam int unsigned E_UF0 = 0;
   localparam int unsigned E_UF1 = 1;
   localparam int unsigned E_CM0 = 2;
   localparam int unsigned E_CM1 = 3;
endpackage

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
module ptmr_prescaler #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic src_i,
   output logic tick_o
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("ptmr_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick_o = run_i & src_i;
      end else begin : g_div
         logic [PW-1:0] acc_q;
         logic          wrap;
         assign wrap   = (acc_q == PW'(DIV - 1));
         assign tick_o = run_i & src_i & wrap;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      acc_q <= '0;
            else if (!run_i) acc_q <= '0;
            else if (src_i)  acc_q <= wrap ? '0 : acc_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ptmr_counter.sv
`timescale 1ns/1ps
module ptmr_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         step_i,
   input  logic [W-1:0] rld_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] nxt_o,
   output logic         fire_o,
   output logic         uf_o
);
   logic [W-1:0] cnt_q;
   logic         at_zero;

   assign at_zero = (cnt_q == '0);
   assign fire_o  = run_i & step_i;
   assign uf_o    = fire_o & at_zero;
   assign cnt_o   = cnt_q;

   always_comb begin
      if (!run_i)      nxt_o = rld_i;
      else if (fire_o) nxt_o = at_zero ? rld_i : cnt_q - 1'b1;
      else             nxt_o = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt_o;
   end
endmodule

// File: rtl/ptmr_regs.sv
`timescale 1ns/1ps
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int unsigned BUS_W = 4,
   parameter int unsigned CNT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [PT_ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]     wdata,
   input  logic [PT_NEVT-1:0]   set_i,
   input  logic [CNT_W-1:0]     cnt0_i,
   input  logic [CNT_W-1:0]     cnt1_i,
   output logic [BUS_W-1:0]     rdata,
   output logic [1:0]           src_o,
   output logic                 evt_mode_o,
   output logic                 cascade_o,
   output logic [1:0]           run_o,
   output logic [1:0]           pwm_o,
   output logic [CNT_W-1:0]     cmp0_o,
   output logic [CNT_W-1:0]     cmp1_o,
   output logic [CNT_W-1:0]     rld0_o,
   output logic [CNT_W-1:0]     rld1_o,
   output logic [PT_NEVT-1:0]   flag_o,
   output logic [PT_NEVT-1:0]   mask_o
);
   localparam int unsigned HI = CNT_W - 1;
   localparam int unsigned LO = BUS_W - 1;

   logic [PT_NEVT-1:0] clr;

   assign clr = (wr_en && addr == A_FLAG) ? wdata[PT_NEVT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_o      <= '0;
         evt_mode_o <= 1'b0;
         cascade_o  <= 1'b0;
         run_o      <= '0;
         pwm_o      <= '0;
         cmp0_o     <= '0;
         cmp1_o     <= '0;
         rld0_o     <= '0;
         rld1_o     <= '0;
         mask_o     <= '0;
      end else if (wr_en) begin
         case (addr)
            A_SRC:   src_o <= wdata[1:0];
            A_MODE:  begin evt_mode_o <= wdata[0]; cascade_o <= wdata[1]; end
            A_RUN:   run_o <= wdata[1:0];
            A_PWM:   pwm_o <= wdata[1:0];
            A_CMP0L: cmp0_o[LO:0]     <= wdata;
            A_CMP0H: cmp0_o[HI:BUS_W] <= wdata;
            A_CMP1L: cmp1_o[LO:0]     <= wdata;
            A_CMP1H: cmp1_o[HI:BUS_W] <= wdata;
            A_RLD0L: rld0_o[LO:0]     <= wdata;
            A_RLD0H: rld0_o[HI:BUS_W] <= wdata;
            A_RLD1L: rld1_o[LO:0]     <= wdata;
            A_RLD1H: rld1_o[HI:BUS_W] <= wdata;
            A_MASK:  mask_o <= wdata[PT_NEVT-1:0];
            default: ;
         endcase
      end
   end

   // new events take priority over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= '0;
      else        flag_o <= (flag_o & ~clr) | set_i;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_SRC:   rdata[1:0] = src_o;
         A_MODE:  rdata[1:0] = {cascade_o, evt_mode_o};
         A_RUN:   rdata[1:0] = run_o;
         A_PWM:   rdata[1:0] = pwm_o;
         A_CMP0L: rdata = cmp0_o[LO:0];
         A_CMP0H: rdata = cmp0_o[HI:BUS_W];
         A_CMP1L: rdata = cmp1_o[LO:0];
         A_CMP1H: rdata = cmp1_o[HI:BUS_W];
         A_RLD0L: rdata = rld0_o[LO:0];
         A_RLD0H: rdata = rld0_o[HI:BUS_W];
         A_RLD1L: rdata = rld1_o[LO:0];
         A_RLD1H: rdata = rld1_o[HI:BUS_W];
         A_FLAG:  rdata[PT_NEVT-1:0] = flag_o;
         A_MASK:  rdata[PT_NEVT-1:0] = mask_o;
         A_CNT0L: rdata = cnt0_i[LO:0];
         A_CNT0H: rdata = cnt0_i[HI:BUS_W];
         A_CNT1L: rdata = cnt1_i[LO:0];
         A_CNT1H: rdata = cnt1_i[HI:BUS_W];
         default: ;
      endcase
   end
endmodule

// File: rtl/ptmr_dual.sv
`timescale 1ns/1ps
module ptmr_dual
   import ptmr_pkg::*;
#(
   parameter int unsigned BUS_W   = 4,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned PRE_DIV = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slow_tick,
   input  logic                 fast_tick,
   input  logic                 evt_in,
   input  logic                 bus_wr,
   input  logic [PT_ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic [1:0]           tmr_out,
   output logic                 irq
);
   localparam int unsigned WIDE_W = 2 * CNT_W;

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("ptmr_dual: CNT_W must be two bus nibbles wide");
      end
      if (BUS_W < PT_NEVT) begin : g_bad_bus
         $error("ptmr_dual: BUS_W must hold the four event bits");
      end
   endgenerate

   logic [1:0]         src_sel, run_q, pwm_q, pre_run, pre_tick, tog_q;
   logic               evt_mode, cascade, evt_q, evt_edge;
   logic [CNT_W-1:0]   cmp0, cmp1, rld0, rld1, cnt0, cnt1, nxt0, nxt1;
   logic [PT_NEVT-1:0] flag_q, mask_q, flag_set;
   logic               step0, step1, run1_eff, fire0, fire1, uf0, uf1, cm0, cm1;
   logic [WIDE_W-1:0]  wide_cnt, wide_nxt, wide_cmp;

   ptmr_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .set_i(flag_set), .cnt0_i(cnt0), .cnt1_i(cnt1), .rdata(bus_rdata),
      .src_o(src_sel), .evt_mode_o(evt_mode), .cascade_o(cascade), .run_o(run_q),
      .pwm_o(pwm_q), .cmp0_o(cmp0), .cmp1_o(cmp1), .rld0_o(rld0), .rld1_o(rld1),
      .flag_o(flag_q), .mask_o(mask_q)
   );

   // prescalers stop where a mode overrides their timer's clock source
   assign pre_run[0] = run_q[0] & ~evt_mode;
   assign pre_run[1] = run_q[1] & ~cascade;

   for (genvar i = 0; i < 2; i++) begin : g_pre
      logic src;
      assign src = src_sel[i] ? fast_tick : slow_tick;
      ptmr_prescaler #(.DIV(PRE_DIV)) i_pre (
         .clk(clk), .rst_n(rst_n), .run_i(pre_run[i]), .src_i(src), .tick_o(pre_tick[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= evt_in;
   end
   assign evt_edge = evt_in & ~evt_q;

   assign step0    = evt_mode ? evt_edge : pre_tick[0];
   assign run1_eff = cascade ? run_q[0] : run_q[1];
   assign step1    = cascade ? uf0 : pre_tick[1];

   ptmr_counter #(.W(CNT_W)) i_cnt0 (
      .clk(clk), .rst_n(rst_n), .run_i(run_q[0]), .step_i(step0), .rld_i(rld0),
      .cnt_o(cnt0), .nxt_o(nxt0), .fire_o(fire0), .uf_o(uf0)
   );
   ptmr_counter #(.W(CNT_W)) i_cnt1 (
      .clk(clk), .rst_n(rst_n), .run_i(run1_eff), .step_i(step1), .rld_i(rld1),
      .cnt_o(cnt1), .nxt_o(nxt1), .fire_o(fire1), .uf_o(uf1)
   );

   assign wide_cnt = {cnt1, cnt0};
   assign wide_nxt = {nxt1, nxt0};
   assign wide_cmp = {cmp1, cmp0};

   assign cm0 = fire0 & (nxt0 == cmp0);
   assign cm1 = cascade ? (fire0 & (wide_nxt == wide_cmp)) : (fire1 & (nxt1 == cmp1));

   always_comb begin
      flag_set        = '0;
      flag_set[E_UF0] = uf0;
      flag_set[E_UF1] = uf1;
      flag_set[E_CM0] = cm0;
      flag_set[E_CM1] = cm1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_q <= '0;
      else        tog_q <= tog_q ^ {uf1, uf0};
   end

   assign tmr_out[0] = pwm_q[0] ? (cnt0 > cmp0) : tog_q[0];
   assign tmr_out[1] = pwm_q[1] ? (cascade ? (wide_cnt > wide_cmp) : (cnt1 > cmp1)) : tog_q[1];

   assign irq = |(flag_q & mask_q);
endmodule

// File: rtl/ptmr_dual_chk.sv
`timescale 1ns/1ps
module ptmr_dual_chk
   import ptmr_pkg::*;
#(
   parameter int unsigned BUS_W = 4,
   parameter int unsigned CNT_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic [PT_ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]     bus_wdata,
   input logic [1:0]           run_q,
   input logic                 evt_mode,
   input logic                 cascade,
   input logic                 evt_edge,
   input logic                 uf0,
   input logic [CNT_W-1:0]     cnt0,
   input logic [CNT_W-1:0]     cnt1,
   input logic [CNT_W-1:0]     rld0,
   input logic [PT_NEVT-1:0]   flag_q,
   input logic [PT_NEVT-1:0]   mask_q,
   input logic [PT_NEVT-1:0]   flag_set,
   input logic                 irq
);
   logic clr_uf0;
   assign clr_uf0 = bus_wr && (bus_addr == A_FLAG) && bus_wdata[E_UF0];

   p_stopped_holds_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[0] |=> cnt0 == $past(rld0));

   p_underflow_reloads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      uf0 |=> cnt0 == $past(rld0));

   p_flag_write_one_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_uf0 && !flag_set[E_UF0]) |=> !flag_q[E_UF0]);

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[E_UF0] && !clr_uf0) |=> flag_q[E_UF0]);

   p_event_mode_ignores_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_mode && run_q[0] && !evt_edge) |=> $stable(cnt0));

   p_cascade_steps_on_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade && run_q[0] && !uf0) |=> $stable(cnt1));

   p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask_q != '0));
endmodule

bind ptmr_dual ptmr_dual_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .run_q(run_q), .evt_mode(evt_mode), .cascade(cascade), .evt_edge(evt_edge), .uf0(uf0),
   .cnt0(cnt0), .cnt1(cnt1), .rld0(rld0), .flag_q(flag_q), .mask_q(mask_q),
   .flag_set(flag_set), .irq(irq)
);

// File: tb/test_ptmr_dual.sv
`timescale 1ns/1ps
module test_ptmr_dual;
   localparam int DIV = 3;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       slow_tick = 1'b0, fast_tick = 1'b0, evt_in = 1'b0, bus_wr = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [3:0] bus_wdata = '0;
   logic [3:0] bus_rdata;
   logic [1:0] tmr_out;
   logic       irq;

   always #2.5 clk = ~clk;

   ptmr_dual #(.PRE_DIV(DIV)) i_ptmr_dual (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
      .evt_in(evt_in), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tmr_out(tmr_out), .irq(irq)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;

   // behavioural reference state
   bit m_src[2], m_run[2], m_pwm[2], m_tog[2];
   bit m_evt, m_casc, m_evq;
   int m_cmp[2], m_rld[2], m_cnt[2], m_p[2];
   int m_flg, m_msk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic int m_rd(input int a);
      case (a)
         0:  return int'(m_src[1]) * 2 + int'(m_src[0]);
         1:  return int'(m_casc) * 2 + int'(m_evt);
         2:  return int'(m_run[1]) * 2 + int'(m_run[0]);
         3:  return int'(m_pwm[1]) * 2 + int'(m_pwm[0]);
         4:  return m_cmp[0] % 16;
         5:  return m_cmp[0] / 16;
         6:  return m_cmp[1] % 16;
         7:  return m_cmp[1] / 16;
         8:  return m_rld[0] % 16;
         9:  return m_rld[0] / 16;
         10: return m_rld[1] % 16;
         11: return m_rld[1] / 16;
         12: return m_flg;
         13: return m_msk;
         16: return m_cnt[0] % 16;
         17: return m_cnt[0] / 16;
         18: return m_cnt[1] % 16;
         19: return m_cnt[1] / 16;
         default: return 0;
      endcase
   endfunction

   function automatic int m_out();
      int o0, o1;
      o0 = m_pwm[0] ? int'(m_cnt[0] > m_cmp[0]) : int'(m_tog[0]);
      if (!m_pwm[1])  o1 = int'(m_tog[1]);
      else if (m_casc) o1 = int'(m_cnt[1] * 256 + m_cnt[0] > m_cmp[1] * 256 + m_cmp[0]);
      else            o1 = int'(m_cnt[1] > m_cmp[1]);
      return o1 * 2 + o0;
   endfunction

   function automatic string tag_of(input int a);
      if (a <= 3) return "R1 control readback";
      if (a == 12) return "R8 R12 flags";
      if (a >= 16) return "R2 R5 R10 count";
      return "R1 data readback";
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 2; i++) begin
         m_src[i] = 0; m_run[i] = 0; m_pwm[i] = 0; m_tog[i] = 0;
         m_cmp[i] = 0; m_rld[i] = 0; m_cnt[i] = 0; m_p[i] = 0;
      end
      m_evt = 0; m_casc = 0; m_evq = 0; m_flg = 0; m_msk = 0;
   endtask

   task automatic m_step();
      bit edg, srct, prun, s0, s1, r1e, f0, f1, uf0, uf1, cm0, cm1;
      bit tk[2];
      int np[2];
      int n0, n1, setv, clr, wd;
      edg = evt_in && !m_evq;
      for (int i = 0; i < 2; i++) begin
         srct  = m_src[i] ? fast_tick : slow_tick;
         prun  = (i == 0) ? (m_run[0] && !m_evt) : (m_run[1] && !m_casc);
         tk[i] = 0;
         np[i] = m_p[i];
         if (!prun) np[i] = 0;
         else if (srct) begin
            if (m_p[i] == DIV - 1) begin np[i] = 0; tk[i] = 1; end
            else np[i] = m_p[i] + 1;
         end
      end
      s0  = m_evt ? edg : tk[0];
      f0  = m_run[0] && s0;
      uf0 = f0 && (m_cnt[0] == 0);
      if (!m_run[0]) n0 = m_rld[0];
      else if (f0)   n0 = (m_cnt[0] == 0) ? m_rld[0] : m_cnt[0] - 1;
      else           n0 = m_cnt[0];
      r1e = m_casc ? m_run[0] : m_run[1];
      s1  = m_casc ? uf0 : tk[1];
      f1  = r1e && s1;
      uf1 = f1 && (m_cnt[1] == 0);
      if (!r1e)    n1 = m_rld[1];
      else if (f1) n1 = (m_cnt[1] == 0) ? m_rld[1] : m_cnt[1] - 1;
      else         n1 = m_cnt[1];
      cm0 = f0 && (n0 == m_cmp[0]);
      cm1 = m_casc ? (f0 && (n1 * 256 + n0 == m_cmp[1] * 256 + m_cmp[0]))
                   : (f1 && (n1 == m_cmp[1]));
      setv = int'(uf0) + 2 * int'(uf1) + 4 * int'(cm0) + 8 * int'(cm1);
      wd   = int'(bus_wdata);
      clr  = (bus_wr && bus_addr == 5'd12) ? wd : 0;
      m_flg = ((m_flg & ~clr) | setv) & 15;
      m_tog[0] = m_tog[0] ^ uf0;
      m_tog[1] = m_tog[1] ^ uf1;
      m_cnt[0] = n0; m_cnt[1] = n1;
      m_p[0] = np[0]; m_p[1] = np[1];
      m_evq = evt_in;
      if (bus_wr) begin
         case (int'(bus_addr))
            0:  begin m_src[0] = bus_wdata[0]; m_src[1] = bus_wdata[1]; end
            1:  begin m_evt = bus_wdata[0]; m_casc = bus_wdata[1]; end
            2:  begin m_run[0] = bus_wdata[0]; m_run[1] = bus_wdata[1]; end
            3:  begin m_pwm[0] = bus_wdata[0]; m_pwm[1] = bus_wdata[1]; end
            4:  m_cmp[0] = (m_cmp[0] & 240) | wd;
            5:  m_cmp[0] = (m_cmp[0] & 15) | (wd * 16);
            6:  m_cmp[1] = (m_cmp[1] & 240) | wd;
            7:  m_cmp[1] = (m_cmp[1] & 15) | (wd * 16);
            8:  m_rld[0] = (m_rld[0] & 240) | wd;
            9:  m_rld[0] = (m_rld[0] & 15) | (wd * 16);
            10: m_rld[1] = (m_rld[1] & 240) | wd;
            11: m_rld[1] = (m_rld[1] & 15) | (wd * 16);
            13: m_msk = wd;
            default: ;
         endcase
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // model advance at the edge, comparison 1 ns later
   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else        m_step();
      #1;
      chk("R6 R7 R11 tmr_out", int'(tmr_out), m_out());
      chk("R9 irq", int'(irq), int'((m_flg & m_msk) != 0));
      chk(tag_of(int'(bus_addr)), int'(bus_rdata), m_rd(int'(bus_addr)));
   end

   // oscillator strobes: fast every 2nd cycle, slow every 9th
   always @(negedge clk) begin
      fast_tick <= (cyc % 2) == 0;
      slow_tick <= (cyc % 9) == 0;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected below 60000", cyc);
         finish_run();
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a[4:0]; bus_wdata = d[3:0];
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         case (k % 5)
            0: bus_addr = 5'd16;
            1: bus_addr = 5'd17;
            2: bus_addr = 5'd18;
            3: bus_addr = 5'd19;
            default: bus_addr = 5'd12;
         endcase
      end
   endtask

   task automatic rdchk(input string tag, input int a, input int exp);
      @(negedge clk);
      bus_addr = a[4:0];
      #1;
      chk(tag, int'(bus_rdata), exp);
   endtask

   task automatic pulse_evt();
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk);
      @(negedge clk); evt_in = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of every address
      for (int a = 0; a < 20; a++) rdchk("R1 reset value", a, 0);
      chk("R6 output low after reset", int'(tmr_out), 0);
      chk("R9 irq low after reset", int'(irq), 0);

      // R1: only bits [1:0] of a control register exist
      wr(0, 15);
      rdchk("R1 unused bits read 0", 0, 3);
      wr(0, 0);

      // R2 R5 R6 R12: timer 0 from the slow strobe, toggle output
      wr(8, 5); wr(4, 2); wr(13, 15); wr(2, 1);
      idle(400);
      rdchk("R5 underflow flag set", 12, m_rd(12) | 1);

      // R8: writing 0 leaves flags, writing 1 clears them
      wr(12, 0);
      rdchk("R8 write 0 no effect", 12, m_rd(12));
      wr(12, 15);
      rdchk("R8 write 1 clears", 12, m_rd(12));

      // R9: masked flags still set, irq stays low
      wr(13, 0);
      idle(400);
      chk("R9 irq low while masked", int'(irq), 0);
      @(negedge clk); bus_addr = 5'd12; #1;
      chk("R9 flags set while masked", int'(bus_rdata != 0), 1);
      wr(13, 15);

      // R2 R7: fast strobe, PWM output on timer 0
      wr(0, 1); wr(3, 1);
      idle(200);

      // R3: event mode with the source select set to fast
      wr(2, 0); wr(8, 10); wr(9, 0); wr(1, 1); wr(0, 1); wr(2, 1);
      pulse_evt(); pulse_evt(); pulse_evt();
      rdchk("R3 three edges counted", 16, 7);
      idle(100);
      rdchk("R3 source strobes ignored", 16, 7);
      rdchk("R3 high nibble", 17, 0);
      pulse_evt();
      rdchk("R3 fourth edge", 16, 6);

      // R10 R11 R12: cascade, timer 1 run bit left at 0
      wr(2, 0); wr(1, 2); wr(8, 2); wr(10, 1); wr(11, 0);
      wr(4, 1); wr(5, 0); wr(6, 1); wr(7, 0);
      wr(3, 2); wr(0, 3); wr(12, 15);
      wr(2, 1);
      idle(600);

      // R7 R12: timer 1 on its own, PWM
      wr(2, 0); wr(1, 0);
      wr(10, 1); wr(11, 2); wr(6, 0); wr(7, 1);
      wr(2, 2);
      idle(500);

      // R4: stopped timer shows its reload value
      wr(2, 0);
      idle(2);
      rdchk("R4 reload low", 18, 1);
      rdchk("R4 reload high", 19, 2);

      idle(5);
      finish_run();
   end
endmodule